// File: doc/BRIEF.md
# Raw NAND Phase Sequencer

This block sits behind a simple word-wide register port and drives an 8-bit raw NAND flash bus one phase at a time. Software picks the phase kind (command, address, data-out or data-in) through a control word. It then writes transmit words that carry one to four bytes. The block moves each byte onto the bus with the matching latch and enable strobes, and for every transmit word it returns one receive word through a read port.

The byte count of a transmit word comes from the offset it is written to, not from a length field. Received bytes come back in the upper byte lanes of the read word. Chip-select can be held low by software across a whole multi-phase flash operation, or left to follow the sequencer's busy state. A controller enable clears the FIFOs and stops the sequencer. A status word reports FIFO levels, a sticky transmit-overflow flag and the flash ready pin. Strobe low and high times are counted in clock cycles.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset, chip-select, write-enable and read-enable are high, both latch strobes are low, the data bus is not driven, and the status word at 0x04 reads with bit 0 (TX empty), bit 1 (TX not full) and bit 3 (RX not full) set, bit 2 (RX not empty) and bit 8 (overflow) clear, and bit 26 equal to the ready pin.
- R2: A write to offset 0x14, 0x18, 0x1C or 0x20 queues a word of 4, 1, 2 or 3 bytes. The bytes go on the bus starting from bits 7:0 and moving upward.
- R3: The phase kind is taken from the control word at 0x30 when a word starts: bit 23 set gives data-in; otherwise a nonzero bits 16:14 (address byte count) gives address; otherwise bits 7:6 equal to 3 give data-out; anything else gives command. Command bytes pulse write-enable low with the command latch high. Address bytes do the same with the address latch high. Data-out bytes pulse write-enable with both latches low.
- R4: In a data-in phase, each byte pulses read-enable low, the data bus is not driven, and the input byte is captured on the edge where read-enable returns high.
- R5: Each transmit word yields exactly one receive word. For n bytes, byte k sits in lane 4−n+k and the lower lanes are zero. Write phases return the bytes they drove; read phases return the bytes they captured.
- R6: A read of offset 0x24 while the receive FIFO is empty returns 0xFFFFFFFF and changes no state.
- R7: A transmit write while the transmit FIFO is full is dropped and sets status bit 8. The bit stays set until the controller is disabled.
- R8: With config bits 1 and 0 both set, chip-select stays low across all phases. With bit 1 set and bit 0 clear, it stays high. With bit 1 clear, it is low only while a word is on the bus.
- R9: Register 0x40 holds the strobe low time in bits 7:0 and the high time in bits 15:8, in clock cycles, with 0 treated as 1. Both reset to 5, which gives a 10-cycle byte.
- R10: While enable bit 0 at 0x10 is clear, both FIFOs are held empty, the sequencer is idle, status bit 8 is cleared and transmit writes are ignored.
- R11: Status bit 26 follows the flash ready/busy pin.
- R12: Write-enable and read-enable are never low together, the two latch strobes are never high together, and the bus is never driven while read-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at 0x24) |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| nand_ce_n | output | 1 | Flash chip-select, active low |
| nand_cle | output | 1 | Command latch strobe |
| nand_ale | output | 1 | Address latch strobe |
| nand_we_n | output | 1 | Write-enable, active low |
| nand_re_n | output | 1 | Read-enable, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rb | input | 1 | Flash ready (high) / busy (low) |

## Verification
Assertions check the bus rules on every cycle: strobe exclusivity, no bus drive during read-enable, no FIFO push when full or pop when empty, an idle bus whenever the block is disabled, and the overflow flag staying set while enabled. Only the bench scenarios can show byte order per offset, phase decoding into latch strobes, receive-word lane packing, strobe pulse widths from the timing register, and chip-select behaviour across phases. A scoreboard compares every latched write byte against the expected sequence.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DOUT, PH_DIN} phase_e;

  localparam logic [7:0] OFF_CFG   = 8'h00;
  localparam logic [7:0] OFF_STAT  = 8'h04;
  localparam logic [7:0] OFF_EN    = 8'h10;
  localparam logic [7:0] OFF_TXLO  = 8'h14;
  localparam logic [7:0] OFF_TXHI  = 8'h20;
  localparam logic [7:0] OFF_RX    = 8'h24;
  localparam logic [7:0] OFF_PHASE = 8'h30;
  localparam logic [7:0] OFF_OCNT  = 8'h3C;
  localparam logic [7:0] OFF_TIME  = 8'h40;

  // true when the offset is one of the four transmit ports
  function automatic logic is_tx_port(input logic [7:0] off);
    return (off >= OFF_TXLO) && (off <= OFF_TXHI) && (off[1:0] == 2'b00);
  endfunction

  // byte count carried by a transmit port: the port index, with index 0 meaning 4
  function automatic logic [2:0] tx_port_bytes(input logic [7:0] off);
    logic [7:0] d;
    d = off - OFF_TXLO;
    return (d[3:2] == 2'd0) ? 3'd4 : {1'b0, d[3:2]};
  endfunction

  // phase kind from the control word, read bit first, then address count, then data width
  function automatic phase_e phase_of(input logic [31:0] w);
    if (w[23])                   return PH_DIN;
    else if (w[16:14] != 3'd0)   return PH_ADDR;
    else if (w[7:6] == 2'b11)    return PH_DOUT;
    else                         return PH_CMD;
  endfunction

  // move n collected bytes (lanes 0..n-1) into the top n lanes
  function automatic logic [31:0] rx_align(input logic [31:0] acc, input logic [2:0] n);
    case (n)
      3'd1:    return acc << 24;
      3'd2:    return acc << 16;
      3'd3:    return acc << 8;
      default: return acc;
    endcase
  endfunction

endpackage

// File: rtl/nbs_fifo.sv
module nbs_fifo #(
  parameter int W     = 35,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wr_ptr, rd_ptr;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign rdata = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !clear) mem[wr_ptr[AW-1:0]] <= wdata;
  end

  // R7
  push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear) |-> !full);

  // R6
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear) |-> !empty);

endmodule

// File: rtl/nbs_engine.sv
module nbs_engine
  import nbs_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tx_valid,
  input  logic [31:0]   tx_data,
  input  logic [2:0]    tx_cnt,
  input  logic          rx_ready,
  input  phase_e        phase_i,
  input  logic [TW-1:0] lo_cyc,
  input  logic [TW-1:0] hi_cyc,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [31:0]   rx_word,
  output logic          busy,
  output logic          cle,
  output logic          ale,
  output logic          we_n,
  output logic          re_n,
  output logic [7:0]    dq_o,
  output logic          dq_oe,
  input  logic [7:0]    dq_i
);
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_e;

  // zero programmed cycles count as one
  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  st_e           st_q;
  phase_e        kind_q;
  logic [31:0]   sh_q, acc_q;
  logic [2:0]    n_q;
  logic [1:0]    idx_q;
  logic [TW-1:0] tmr_q;

  logic [TW-1:0] lo_eff, hi_eff;
  logic          tmr_done, is_last, strobe_edge, word_start;
  logic [7:0]    cur_byte, got_byte;

  assign lo_eff      = at_least_one(lo_cyc);
  assign hi_eff      = at_least_one(hi_cyc);
  assign tmr_done    = (tmr_q == '0);
  assign is_last     = ({1'b0, idx_q} == (n_q - 3'd1));
  assign cur_byte    = sh_q[{idx_q, 3'b000} +: 8];
  assign got_byte    = (kind_q == PH_DIN) ? dq_i : cur_byte;
  assign word_start  = (st_q == S_IDLE) && tx_valid && rx_ready;
  assign strobe_edge = (st_q == S_LOW) && tmr_done;

  assign tx_pop  = word_start;
  assign rx_push = (st_q == S_HIGH) && tmr_done && is_last;
  assign rx_word = rx_align(acc_q, n_q);
  assign busy    = (st_q != S_IDLE);

  assign cle   = busy && (kind_q == PH_CMD);
  assign ale   = busy && (kind_q == PH_ADDR);
  assign we_n  = !((st_q == S_LOW) && (kind_q != PH_DIN));
  assign re_n  = !((st_q == S_LOW) && (kind_q == PH_DIN));
  assign dq_oe = busy && (kind_q != PH_DIN);
  assign dq_o  = dq_oe ? cur_byte : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= PH_CMD;
      sh_q   <= '0;
      acc_q  <= '0;
      n_q    <= 3'd1;
      idx_q  <= '0;
      tmr_q  <= '0;
    end else if (clear) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      tmr_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (word_start) begin
          sh_q   <= tx_data;
          n_q    <= tx_cnt;
          kind_q <= phase_i;
          acc_q  <= '0;
          idx_q  <= '0;
          tmr_q  <= lo_eff - 1'b1;
          st_q   <= S_LOW;
        end
        S_LOW: if (tmr_done) begin
          acc_q[{idx_q, 3'b000} +: 8] <= got_byte;
          tmr_q <= hi_eff - 1'b1;
          st_q  <= S_HIGH;
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
        S_HIGH: if (tmr_done) begin
          if (is_last) begin
            st_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            tmr_q <= lo_eff - 1'b1;
            st_q  <= S_LOW;
          end
        end else begin
          tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  // R12
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R4
  din_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !dq_oe);

  // R5
  one_word_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |=> !busy);

  // R4
  capture_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || clear)
    (strobe_edge && kind_q == PH_DIN) |=> re_n);

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nbs_pkg::*;
#(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int TW       = 8,
  parameter int LO_RST   = 5,
  parameter int HI_RST   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb
);
  localparam int TXW = 32 + 3;

  logic [1:0]    cfg_q;
  logic          en_q;
  logic [31:0]   phase_q, ocnt_q;
  logic [TW-1:0] lo_q, hi_q;
  logic          ovf_q;

  logic           tx_hit, tx_push, tx_drop, tx_pop, tx_full, tx_empty;
  logic [TXW-1:0] tx_head;
  logic           rx_pop, rx_push, rx_full, rx_empty;
  logic [31:0]    rx_head, rx_word;
  logic           eng_busy, fifo_clear;

  assign fifo_clear = !en_q;
  assign tx_hit     = reg_wr && is_tx_port(reg_addr);
  assign tx_push    = tx_hit && en_q && !tx_full;
  assign tx_drop    = tx_hit && en_q && tx_full;
  assign rx_pop     = reg_rd && (reg_addr == OFF_RX) && !rx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      phase_q <= '0;
      ocnt_q  <= '0;
      lo_q    <= TW'(LO_RST);
      hi_q    <= TW'(HI_RST);
      ovf_q   <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          OFF_CFG:   cfg_q   <= reg_wdata[1:0];
          OFF_EN:    en_q    <= reg_wdata[0];
          OFF_PHASE: phase_q <= reg_wdata;
          OFF_OCNT:  ocnt_q  <= reg_wdata;
          OFF_TIME: begin
            lo_q <= reg_wdata[TW-1:0];
            hi_q <= reg_wdata[2*TW-1:TW];
          end
          default: ;
        endcase
      end
      if (!en_q)        ovf_q <= 1'b0;
      else if (tx_drop) ovf_q <= 1'b1;
    end
  end

  nbs_fifo #(.W(TXW), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear),
    .push(tx_push), .wdata({tx_port_bytes(reg_addr), reg_wdata}),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  nbs_fifo #(.W(32), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear),
    .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_head), .full(rx_full), .empty(rx_empty)
  );

  nbs_engine #(.TW(TW)) u_eng (
    .clk(clk), .rst_n(rst_n), .clear(fifo_clear),
    .tx_valid(!tx_empty), .tx_data(tx_head[31:0]), .tx_cnt(tx_head[34:32]),
    .rx_ready(!rx_full), .phase_i(phase_of(phase_q)),
    .lo_cyc(lo_q), .hi_cyc(hi_q),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .busy(eng_busy),
    .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe(nand_dq_oe), .dq_i(nand_dq_i)
  );

  assign nand_ce_n = !(cfg_q[1] ? cfg_q[0] : eng_busy);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_CFG:   reg_rdata = {30'b0, cfg_q};
      OFF_STAT:  reg_rdata = {5'b0, nand_rb, 17'b0, ovf_q, 4'b0,
                             !rx_full, !rx_empty, !tx_full, tx_empty};
      OFF_EN:    reg_rdata = {31'b0, en_q};
      OFF_RX:    reg_rdata = rx_empty ? 32'hFFFF_FFFF : rx_head;
      OFF_PHASE: reg_rdata = phase_q;
      OFF_OCNT:  reg_rdata = ocnt_q;
      OFF_TIME:  reg_rdata = 32'({hi_q, lo_q});
      default:   reg_rdata = '0;
    endcase
  end

  // R10
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (nand_we_n && nand_re_n && !nand_dq_oe));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && en_q) |=> ovf_q);

  // R8
  manual_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q == 2'b10) |-> nand_ce_n);

endmodule

// File: tb/nand_phase_seq_tb.sv
module nand_phase_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i;
  logic        nand_rb = 1'b1;

  int checks = 0;
  int errors = 0;
  logic mon_on = 1'b0;
  logic [7:0] din_base = 8'hA0;
  int rd_cnt = 0;
  int we_rises = 0;
  int re_rises = 0;
  realtime we_fall_t = 0;
  realtime we_low_ns = 0;
  logic [9:0] exp_bus[$];

  always #5 clk = ~clk;

  nand_phase_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
    .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
  );

  assign nand_dq_i = din_base + rd_cnt[7:0];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // flash-side monitor: each write-enable rising edge is one latched byte
  always @(negedge nand_we_n) if (mon_on) we_fall_t = $realtime;
  always @(posedge nand_we_n) begin
    if (mon_on) begin
      logic [9:0] got;
      logic [9:0] exp;
      we_rises++;
      we_low_ns = $realtime - we_fall_t;
      got = {nand_cle, nand_ale, nand_dq_o};
      if (exp_bus.size() == 0) begin
        chk(1'b0, "R3 unexpected bus byte", 32'(got), 32'h3FF);
      end else begin
        exp = exp_bus.pop_front();
        chk(got == exp, "R2/R3 latched byte", 32'(got), 32'(exp));
        chk(nand_dq_oe == 1'b1, "R3 bus driven on write", 32'(nand_dq_oe), 32'h1);
      end
    end
  end
  always @(posedge nand_re_n) begin
    if (mon_on) begin
      re_rises++;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #2 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  task automatic expect_bus(input logic cle, input logic ale, input logic [7:0] b);
    exp_bus.push_back({cle, ale, b});
  endtask

  task automatic wait_rx(input string req);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      reg_read(8'h04, s);
      if (s[2]) return;
    end
    chk(1'b0, req, 32'h0, 32'h4);
  endtask

  task automatic read_rx_expect(input string req, input logic [31:0] exp);
    logic [31:0] d;
    wait_rx(req);
    reg_read(8'h24, d);
    chk(d == exp, req, d, exp);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 32'h0, 32'h1);
    finish_report();
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;

    // R1 reset state
    chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe} == 6'b111000,
        "R1 idle pins", 32'({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}), 32'h38);
    reg_read(8'h04, d);
    chk(d == 32'h0400_000B, "R1 status", d, 32'h0400_000B);
    // R6 empty receive read
    reg_read(8'h24, d);
    chk(d == 32'hFFFF_FFFF, "R6 empty rx read", d, 32'hFFFF_FFFF);
    reg_read(8'h04, d);
    chk(d[3:0] == 4'hB, "R6 no state change", 32'(d[3:0]), 32'hB);

    reg_write(8'h10, 32'h0);
    reg_write(8'h10, 32'h1);
    reg_write(8'h00, 32'h3);
    @(negedge clk);
    chk(nand_ce_n == 1'b0, "R8 manual assert", 32'(nand_ce_n), 32'h0);

    // R3 command phase, one byte via 0x18 (R2)
    reg_write(8'h30, 32'h0000_0003);
    expect_bus(1'b1, 1'b0, 8'h70);
    reg_write(8'h18, 32'h0000_0070);
    read_rx_expect("R5 one-byte rx word", 32'h7000_0000);
    chk(we_low_ns == 50.0, "R9 default low time", 32'(int'(we_low_ns)), 32'd50);

    // R3 address phase, three bytes via 0x20 (R2)
    reg_write(8'h30, (32'd3 << 3) | (32'd3 << 14));
    expect_bus(1'b0, 1'b1, 8'hCC);
    expect_bus(1'b0, 1'b1, 8'hBB);
    expect_bus(1'b0, 1'b1, 8'hAA);
    reg_write(8'h20, 32'h00AA_BBCC);
    read_rx_expect("R5 three-byte rx word", 32'hAABB_CC00);
    chk(nand_ce_n == 1'b0, "R8 cs held across phases", 32'(nand_ce_n), 32'h0);

    // R3 data-out phase, four bytes via 0x14 (R2)
    reg_write(8'h3C, 32'd4);
    reg_read(8'h3C, d);
    chk(d == 32'd4, "R3 out count readback", d, 32'd4);
    reg_write(8'h30, 32'd3 << 6);
    expect_bus(1'b0, 1'b0, 8'h11);
    expect_bus(1'b0, 1'b0, 8'h22);
    expect_bus(1'b0, 1'b0, 8'h33);
    expect_bus(1'b0, 1'b0, 8'h44);
    reg_write(8'h14, 32'h4433_2211);
    read_rx_expect("R5 four-byte rx word", 32'h4433_2211);

    // R4 data-in phase, two bytes via 0x1C
    reg_write(8'h3C, 32'd0);
    reg_write(8'h30, (32'd1 << 23) | (32'd3 << 6));
    base = we_rises;
    rd_cnt = 0;
    reg_write(8'h1C, 32'hFFFF_FFFF);
    read_rx_expect("R4 R5 captured bytes", 32'hA1A0_0000);
    chk(re_rises == 2, "R4 read strobe count", 32'(re_rises), 32'd2);
    chk(we_rises == base, "R4 no write strobe", 32'(we_rises), 32'(base));

    // R9 timing register: low 2, high 0 -> 1
    reg_write(8'h40, 32'h0000_0002);
    reg_write(8'h30, 32'h0000_0003);
    expect_bus(1'b1, 1'b0, 8'hFF);
    reg_write(8'h18, 32'h0000_00FF);
    read_rx_expect("R9 short cycle rx", 32'hFF00_0000);
    chk(we_low_ns == 20.0, "R9 programmed low time", 32'(int'(we_low_ns)), 32'd20);

    // R8 manual enable with deassert, then automatic mode
    reg_write(8'h40, 32'h0000_0505);
    reg_write(8'h00, 32'h2);
    @(negedge clk);
    chk(nand_ce_n == 1'b1, "R8 manual deassert", 32'(nand_ce_n), 32'h1);
    reg_write(8'h00, 32'h0);
    expect_bus(1'b1, 1'b0, 8'h90);
    reg_write(8'h18, 32'h0000_0090);
    @(posedge clk); #2;
    chk(nand_ce_n == 1'b0, "R8 auto cs while busy", 32'(nand_ce_n), 32'h0);
    read_rx_expect("R8 auto word rx", 32'h9000_0000);
    chk(nand_ce_n == 1'b1, "R8 auto cs idle", 32'(nand_ce_n), 32'h1);

    // R7 overflow: slow strobes, six back-to-back writes into a 4-deep queue
    reg_write(8'h40, 32'h0000_1414);
    for (int i = 0; i < 5; i++) expect_bus(1'b1, 1'b0, 8'h31 + 8'(i));
    for (int i = 0; i < 6; i++) reg_write(8'h18, 32'h31 + i);
    reg_read(8'h04, d);
    chk(d[8] == 1'b1, "R7 overflow set", 32'(d[8]), 32'h1);
    chk(d[1] == 1'b0, "R7 tx full", 32'(d[1]), 32'h0);
    for (int i = 0; i < 5; i++) read_rx_expect("R7 accepted words", (32'h31 + i) << 24);
    reg_read(8'h04, d);
    chk(d[8] == 1'b1, "R7 overflow sticky", 32'(d[8]), 32'h1);

    // R10 disable clears and ignores
    reg_write(8'h10, 32'h0);
    @(negedge clk);
    reg_read(8'h04, d);
    chk(d[8:0] == 9'h00B, "R10 cleared status", 32'(d[8:0]), 32'h00B);
    base = we_rises;
    reg_write(8'h18, 32'h0000_0055);
    repeat (60) @(negedge clk);
    chk(we_rises == base, "R10 write ignored on bus", 32'(we_rises), 32'(base));
    reg_read(8'h04, d);
    chk(d[2:0] == 3'b011, "R10 queues stay empty", 32'(d[2:0]), 32'h3);
    reg_write(8'h10, 32'h1);

    // R11 ready pin
    nand_rb = 1'b0;
    reg_read(8'h04, d);
    chk(d[26] == 1'b0, "R11 busy pin", 32'(d[26]), 32'h0);
    nand_rb = 1'b1;
    reg_read(8'h04, d);
    chk(d[26] == 1'b1, "R11 ready pin", 32'(d[26]), 32'h1);

    chk(exp_bus.size() == 0, "R3 scoreboard drained", 32'(exp_bus.size()), 32'h0);
    finish_report();
  end
endmodule